// File: doc/BRIEF.md
# Shadow-Nonvolatile SRAM Store Controller

This block models a word-wide memory built in two layers: a fast static array that a host reads and writes through an SRAM-style port, and a nonvolatile shadow array of the same size behind it. A STORE copies the whole static array into the shadow array. A RECALL copies the shadow array back into the static array. Both copies are modelled as a sequential sweep, one address per clock cycle, and the SRAM port is blocked for the whole sweep.

A STORE can come from three sources: an external device pulling the shared busy pin low, a software sequence of six reads at fixed addresses, or a rising edge on a digital power-fail flag that stands in for the supply monitor. Sources that fire in the same cycle are merged into a single STORE, and triggers that arrive while an operation runs are dropped. The busy pin is bidirectional. The block drives it low for the whole of an operation, drives it high for a few cycles after a STORE, and then lets it float to the board pull-up. A RECALL runs by itself after every reset and can also be requested by its own read sequence. A saturating counter records completed STOREs.

The port uses active-low controls with a 16-bit data word split into an upper and a lower byte. Read data is registered: it appears one cycle after the clock edge that accepts the read, together with one drive-enable bit per byte.

Top module: `shadow_nvram_ctrl`

## Requirements
- R1: A read is accepted at a clock edge when the block is idle, `ce_n` and `oe_n` are 0, and `we_n` and `busy_pin_in` are 1. After that edge `rdata` holds the addressed word and `dq_oe` is {~ub_n, ~lb_n}. Bit 1 drives `rdata[15:8]` and bit 0 drives `rdata[7:0]`. A byte that is not enabled reads as zero. When no read is accepted, `dq_oe` is 0.
- R2: A write is accepted at a clock edge when the block is idle, `ce_n` and `we_n` are 0, and `busy_pin_in` is 1. Only the upper byte (when `ub_n` is 0) and the lower byte (when `lb_n` is 0) of the addressed word take `wdata`.
- R3: After any clock edge at which `we_n` is 0, `dq_oe` is 0, whatever `oe_n` is.
- R4: While the block drives the busy pin (a STORE, a RECALL, or the high phase after a STORE), reads and writes are ignored. Memory contents do not change and `dq_oe` stays 0.
- R5: A falling edge on `busy_pin_in` while the block is idle and not driving the pin starts a STORE.
- R6: When `AUTO_STORE_EN` is 1 (the default), a rising edge on `pwr_fail` while idle starts a STORE. Holding `pwr_fail` high does not start another one.
- R7: Six consecutive accepted reads at `STORE_SEQ` addresses 0x0E, 0x31, 0x1C, 0x23, 0x3F, 0x0B (the defaults for a 6-bit address) start a STORE after the sixth. A read at any other address restarts the matcher. The breaking read counts as the first of a new sequence when its address is the first address of the sequence.
- R8: Six consecutive accepted reads at `RECALL_SEQ` addresses 0x0E, 0x31, 0x1C, 0x23, 0x3F, 0x0C start a RECALL, which leaves the static array equal to the shadow array. If a STORE trigger comes in the same cycle, the STORE wins.
- R9: A STORE drives the busy pin low (`busy_pin_oe`=1, `busy_pin_out`=0) for exactly 2^AW cycles, copies every word to the shadow array, then drives it high for `PULSE_CYC` cycles and releases it (`busy_pin_oe`=0). `op_done` pulses for one cycle as the sweep ends.
- R10: After synchronous reset `rst` is released, a RECALL holds the busy pin low for 2^AW cycles and then releases it without a high phase. The static array then holds the shadow contents, which a reset does not clear.
- R11: Triggers that arrive in the same cycle cause one STORE. Triggers that arrive during an operation are ignored.
- R12: `store_count` goes up by one at the end of each STORE and saturates at `STORE_LIMIT` (default 200000). RECALLs do not change it, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, disabled bytes zero |
| dq_oe | output | 2 | Per-byte output drive enable {upper, lower} |
| busy_pin_in | input | 1 | Level seen on the shared busy pin |
| busy_pin_oe | output | 1 | Block drives the busy pin |
| busy_pin_out | output | 1 | Value driven onto the busy pin |
| pwr_fail | input | 1 | Supply-loss flag, active high |
| op_done | output | 1 | One-cycle pulse at the end of a STORE or RECALL sweep |
| store_count | output | $clog2(STORE_LIMIT+1) | Saturating count of completed STOREs |

## Verification
Several properties are checked on every cycle by the assertions: the data drivers stay off after a write edge and while the block owns the busy pin, disabled bytes read as zero, every sweep ends after a low busy phase, a STORE end leaves the pin driven high, and the counter only steps by one at a sweep end and never passes its limit. Only the bench scenarios can show the behaviour that depends on memory contents and on sequences of events. These are the byte-masked writes, the matching of the two read sequences (including a broken sequence), the merging of simultaneous triggers, the dropping of triggers during a sweep, the exact lengths of the low and high busy phases, and shadow contents that survive a reset and come back through RECALL.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    localparam int WORD_W  = 16;
    localparam int SEQ_LEN = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STORE,
        ST_RECALL,
        ST_PULSE
    } nvs_state_e;

    // Accepted host access for this cycle
    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [1:0] be;   // {upper, lower}, active high
    } port_req_t;

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [1:0]        be
    );
        logic [WORD_W-1:0] r;
        r[15:8] = be[1] ? new_w[15:8] : old_w[15:8];
        r[7:0]  = be[0] ? new_w[7:0]  : old_w[7:0];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] mask_bytes(
        input logic [WORD_W-1:0] w,
        input logic [1:0]        be
    );
        return {w[15:8] & {8{be[1]}}, w[7:0] & {8{be[0]}}};
    endfunction

endpackage

// File: rtl/nvs_seq_match.sv
module nvs_seq_match import nvs_pkg::*; #(
    parameter int AW = 6,
    parameter logic [SEQ_LEN-1:0][AW-1:0] SEQ = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_ok,
    input  logic [AW-1:0] addr,
    output logic          fire
);
    localparam int IW = $clog2(SEQ_LEN);

    logic [IW-1:0] idx;
    logic          hit;

    assign hit  = (addr == SEQ[idx]);
    assign fire = rd_ok && hit && (idx == IW'(SEQ_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (rd_ok) begin
            if (fire)
                idx <= '0;
            else if (hit)
                idx <= idx + 1'b1;
            else if (addr == SEQ[0])
                idx <= IW'(1);
            else
                idx <= '0;
        end
    end
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays import nvs_pkg::*; #(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  port_req_t         req,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              copy_store,
    input  logic              copy_recall,
    input  logic [AW-1:0]     copy_ptr,
    output logic [WORD_W-1:0] rdata,
    output logic [1:0]        dq_oe
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] sram_q   [DEPTH];
    logic [WORD_W-1:0] shadow_q [DEPTH];

    // Nonvolatile layer: no reset, written only by the store sweep
    always_ff @(posedge clk) begin
        if (copy_store)
            shadow_q[copy_ptr] <= sram_q[copy_ptr];
    end

    // Volatile layer: recall sweep or host write (mutually exclusive)
    always_ff @(posedge clk) begin
        if (copy_recall)
            sram_q[copy_ptr] <= shadow_q[copy_ptr];
        else if (req.wr)
            sram_q[addr] <= merge_bytes(sram_q[addr], wdata, req.be);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            dq_oe <= '0;
        end else if (req.rd) begin
            rdata <= mask_bytes(sram_q[addr], req.be);
            dq_oe <= req.be;
        end else begin
            rdata <= '0;
            dq_oe <= '0;
        end
    end
endmodule

// File: rtl/shadow_nvram_ctrl.sv
module shadow_nvram_ctrl import nvs_pkg::*; #(
    parameter int AW            = 6,
    parameter int STORE_LIMIT   = 200000,
    parameter int PULSE_CYC     = 3,
    parameter bit AUTO_STORE_EN = 1'b1,
    parameter logic [SEQ_LEN-1:0][AW-1:0] STORE_SEQ  =
        {6'h0B, 6'h3F, 6'h23, 6'h1C, 6'h31, 6'h0E},
    parameter logic [SEQ_LEN-1:0][AW-1:0] RECALL_SEQ =
        {6'h0C, 6'h3F, 6'h23, 6'h1C, 6'h31, 6'h0E},
    localparam int CW = $clog2(STORE_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [1:0]        dq_oe,
    input  logic              busy_pin_in,
    output logic              busy_pin_oe,
    output logic              busy_pin_out,
    input  logic              pwr_fail,
    output logic              op_done,
    output logic [CW-1:0]     store_count
);
    localparam int DEPTH = 1 << AW;
    localparam int PCW   = $clog2(PULSE_CYC + 1);

    nvs_state_e    state;
    logic [AW-1:0] ptr;
    logic [PCW-1:0] pcnt;
    logic          busy_prev, pf_prev;
    logic          idle, last;
    logic          hw_trig, pf_trig, sw_store, sw_recall;
    logic          start_store, start_recall;
    port_req_t     req;

    assign idle = (state == ST_IDLE);
    assign last = (ptr == AW'(DEPTH - 1));

    always_comb begin
        req.rd = idle && !ce_n && !oe_n && we_n && busy_pin_in;
        req.wr = idle && !ce_n && !we_n && busy_pin_in;
        req.be = {~ub_n, ~lb_n};
    end

    nvs_seq_match #(.AW(AW), .SEQ(STORE_SEQ)) u_store_seq (
        .clk(clk), .rst(rst), .rd_ok(req.rd), .addr(addr), .fire(sw_store)
    );

    nvs_seq_match #(.AW(AW), .SEQ(RECALL_SEQ)) u_recall_seq (
        .clk(clk), .rst(rst), .rd_ok(req.rd), .addr(addr), .fire(sw_recall)
    );

    // Trigger arbitration: all store sources merge, store beats recall
    assign hw_trig      = idle && busy_prev && !busy_pin_in;
    assign pf_trig      = AUTO_STORE_EN && pwr_fail && !pf_prev;
    assign start_store  = idle && (hw_trig || pf_trig || sw_store);
    assign start_recall = idle && sw_recall && !start_store;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RECALL;
            ptr         <= '0;
            pcnt        <= '0;
            busy_prev   <= 1'b0;
            pf_prev     <= 1'b0;
            op_done     <= 1'b0;
            store_count <= '0;
        end else begin
            busy_prev <= busy_pin_in;
            pf_prev   <= pwr_fail;
            op_done   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    ptr <= '0;
                    if (start_store)
                        state <= ST_STORE;
                    else if (start_recall)
                        state <= ST_RECALL;
                end
                ST_STORE: begin
                    ptr <= ptr + 1'b1;
                    if (last) begin
                        state   <= ST_PULSE;
                        pcnt    <= '0;
                        op_done <= 1'b1;
                        if (store_count != CW'(STORE_LIMIT))
                            store_count <= store_count + 1'b1;
                    end
                end
                ST_RECALL: begin
                    ptr <= ptr + 1'b1;
                    if (last) begin
                        state   <= ST_IDLE;
                        op_done <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    pcnt <= pcnt + 1'b1;
                    if (pcnt == PCW'(PULSE_CYC - 1))
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_pin_oe  = !idle;
    assign busy_pin_out = (state == ST_PULSE);

    nvs_arrays #(.AW(AW)) u_arrays (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .addr       (addr),
        .wdata      (wdata),
        .copy_store (state == ST_STORE),
        .copy_recall(state == ST_RECALL),
        .copy_ptr   (ptr),
        .rdata      (rdata),
        .dq_oe      (dq_oe)
    );
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
    parameter int CW          = 18,
    parameter int STORE_LIMIT = 200000
) (
    input logic          clk,
    input logic          rst,
    input logic          we_n,
    input logic [15:0]   rdata,
    input logic [1:0]    dq_oe,
    input logic          busy_pin_oe,
    input logic          busy_pin_out,
    input logic          op_done,
    input logic [CW-1:0] store_count
);
    logic past_ok = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_MASK_LOW: assert property (@(posedge clk) disable iff (rst)
        !dq_oe[0] |-> rdata[7:0] == 8'h00);                              // R1
    AST_MASK_HIGH: assert property (@(posedge clk) disable iff (rst)
        !dq_oe[1] |-> rdata[15:8] == 8'h00);                             // R1
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> dq_oe == 2'b00);                                       // R3
    AST_BLOCKED_IN_OP: assert property (@(posedge clk) disable iff (rst)
        busy_pin_oe |=> dq_oe == 2'b00);                                 // R4
    AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (op_done && busy_pin_oe) |-> busy_pin_out);                      // R9
    AST_SWEEP_LOW: assert property (@(posedge clk) disable iff (rst || !past_ok)
        op_done |-> ($past(busy_pin_oe) && !$past(busy_pin_out)));       // R9
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        store_count <= CW'(STORE_LIMIT));                                // R12
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (store_count != $past(store_count)) |->
        (op_done && store_count == CW'($past(store_count) + 1'b1)));     // R12
endmodule

bind shadow_nvram_ctrl nvs_chk #(.CW(CW), .STORE_LIMIT(STORE_LIMIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .we_n        (we_n),
    .rdata       (rdata),
    .dq_oe       (dq_oe),
    .busy_pin_oe (busy_pin_oe),
    .busy_pin_out(busy_pin_out),
    .op_done     (op_done),
    .store_count (store_count)
);

// File: tb/sim_shadow_nvram_ctrl.sv
module sim_shadow_nvram_ctrl;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int LIMIT = 6;
    localparam int PULSE = 3;
    localparam int CW    = $clog2(LIMIT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b0, lb_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    dq_oe;
    logic          busy_pin_in, busy_pin_oe, busy_pin_out;
    logic          pwr_fail = 1'b0;
    logic          op_done;
    logic [CW-1:0] store_count;
    logic          ext_low = 1'b0;

    // Shared pin: block driver wins, else external pull-down or weak pull-up
    assign busy_pin_in = busy_pin_oe ? busy_pin_out : !ext_low;

    always #5 clk = ~clk;

    shadow_nvram_ctrl #(.AW(AW), .STORE_LIMIT(LIMIT), .PULSE_CYC(PULSE)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .dq_oe(dq_oe), .busy_pin_in(busy_pin_in), .busy_pin_oe(busy_pin_oe),
        .busy_pin_out(busy_pin_out), .pwr_fail(pwr_fail), .op_done(op_done),
        .store_count(store_count)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [15:0] m_sram   [DEPTH];
    logic [15:0] m_shadow [DEPTH];
    int          exp_count = 0;

    localparam logic [5:0] SSEQ [6] = '{6'h0E, 6'h31, 6'h1C, 6'h23, 6'h3F, 6'h0B};
    localparam logic [5:0] RSEQ [6] = '{6'h0E, 6'h31, 6'h1C, 6'h23, 6'h3F, 6'h0C};

    function automatic logic [15:0] f_merge(logic [15:0] o, logic [15:0] n, logic [1:0] be);
        return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
    endfunction

    function automatic logic [15:0] f_mask(logic [15:0] w, logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    function automatic int f_next_count(int c);
        return (c < LIMIT) ? c + 1 : c;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] be,
                            bit oe_low, bit apply);
        ce_n = 1'b0; we_n = 1'b0; oe_n = !oe_low;
        ub_n = !be[1]; lb_n = !be[0]; addr = a; wdata = d;
        tick();
        chk("R3 no drive during write", {30'd0, dq_oe}, 32'd0);
        if (apply) m_sram[a] = f_merge(m_sram[a], d, be);
        bus_idle();
    endtask

    task automatic do_read(logic [AW-1:0] a, logic [1:0] be, string tag);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        ub_n = !be[1]; lb_n = !be[0]; addr = a;
        tick();
        chk(tag, {16'd0, rdata}, {16'd0, f_mask(m_sram[a], be)});
        chk(tag, {30'd0, dq_oe}, {30'd0, be});
        bus_idle();
    endtask

    // Counts busy-low and busy-high cycles from now until the pin is released
    task automatic measure(output int lo, output int hi, output bit done);
        lo = 0; hi = 0; done = 1'b0;
        for (int g = 0; g < 4 * DEPTH; g++) begin
            if (op_done) done = 1'b1;
            if (!busy_pin_oe) break;
            if (busy_pin_out) hi++; else lo++;
            tick();
        end
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 4 * DEPTH && busy_pin_oe; g++) tick();
    endtask

    task automatic stay_idle(int n, string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            if (busy_pin_oe) seen++;
            tick();
        end
        chk(tag, seen, 0);
    endtask

    task automatic hw_store_measured(string tag);
        int lo, hi; bit done;
        ext_low = 1'b1;
        tick();
        ext_low = 1'b0;
        measure(lo, hi, done);
        chk({tag, " R9 low phase"}, lo, DEPTH);
        chk({tag, " R9 high phase"}, hi, PULSE);
        chk({tag, " R9 done pulse"}, {31'd0, done}, 1);
        for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_sram[i];
        exp_count = f_next_count(exp_count);
        chk({tag, " R12 count"}, {29'd0, store_count}, exp_count);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lo, hi; bit done;
        void'($urandom(32'h5EED_0417));

        // Reset state
        repeat (3) tick();
        chk("R10 reset busy driven", {31'd0, busy_pin_oe}, 1);
        chk("R10 reset busy low", {31'd0, busy_pin_out}, 0);
        chk("R1 reset no drive", {30'd0, dq_oe}, 0);
        chk("R12 reset count", {29'd0, store_count}, 0);

        // Power-on recall
        rst = 1'b0;
        measure(lo, hi, done);
        chk("R10 recall low phase", lo, DEPTH);
        chk("R10 recall no high phase", hi, 0);
        chk("R9 recall done pulse", {31'd0, done}, 1);

        // Fill, then random mixed traffic
        for (int i = 0; i < DEPTH; i++) do_write(AW'(i), 16'($urandom), 2'b11, 1'b0, 1'b1);
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a  = AW'($urandom);
            logic [1:0]    be = 2'($urandom);
            if ($urandom % 2 == 0)
                do_write(a, 16'($urandom), be, ($urandom % 2) == 0, 1'b1);  // R2
            else
                do_read(a, be, "R1 R2 random read");
        end
        do_write(6'h05, 16'hA5C3, 2'b10, 1'b0, 1'b1);
        do_read(6'h05, 2'b11, "R2 upper byte only");
        do_write(6'h05, 16'h1234, 2'b01, 1'b1, 1'b1);
        do_read(6'h05, 2'b01, "R2 lower byte only");

        // Hardware store (R5)
        hw_store_measured("R5 hw store");

        // Store with blocked access and a power-fail edge mid-sweep
        ext_low = 1'b1;
        tick();
        ext_low = 1'b0;
        do_write(6'h05, 16'hDEAD, 2'b11, 1'b0, 1'b0);
        ce_n = 1'b0; oe_n = 1'b0; addr = 6'h07;
        tick();
        chk("R4 read blocked", {30'd0, dq_oe}, 0);
        bus_idle();
        pwr_fail = 1'b1;
        wait_idle();
        for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_sram[i];
        exp_count = f_next_count(exp_count);
        stay_idle(12, "R11 trigger in sweep ignored");
        chk("R11 one store counted", {29'd0, store_count}, exp_count);
        do_read(6'h05, 2'b11, "R4 write blocked");
        pwr_fail = 1'b0;
        tick();

        // Power-fail store, level held high
        pwr_fail = 1'b1;
        tick();
        measure(lo, hi, done);
        chk("R6 pf store low phase", lo, DEPTH);
        exp_count = f_next_count(exp_count);
        stay_idle(20, "R6 held level no restart");
        chk("R6 pf count", {29'd0, store_count}, exp_count);
        pwr_fail = 1'b0;
        tick();

        // Merged triggers
        ext_low = 1'b1; pwr_fail = 1'b1;
        tick();
        ext_low = 1'b0;
        wait_idle();
        exp_count = f_next_count(exp_count);
        stay_idle(12, "R11 merged single store");
        chk("R11 merged count", {29'd0, store_count}, exp_count);
        pwr_fail = 1'b0;
        tick();

        // Software store
        for (int i = 0; i < 8; i++) do_write(AW'($urandom), 16'($urandom), 2'b11, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) do_read(SSEQ[i], 2'b11, "R7 seq read");
        chk("R7 sw store started", {31'd0, busy_pin_oe}, 1);
        wait_idle();
        for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_sram[i];
        exp_count = f_next_count(exp_count);
        chk("R7 sw store count", {29'd0, store_count}, exp_count);

        // Broken sequence
        for (int i = 0; i < 4; i++) do_read(SSEQ[i], 2'b11, "R7 seq read");
        do_read(6'h05, 2'b11, "R7 breaking read");
        do_read(SSEQ[4], 2'b11, "R7 seq read");
        do_read(SSEQ[5], 2'b11, "R7 seq read");
        stay_idle(5, "R7 broken sequence no store");
        chk("R7 broken count", {29'd0, store_count}, exp_count);

        // Software recall
        for (int i = 0; i < DEPTH; i += 3) do_write(AW'(i), 16'($urandom), 2'b11, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) do_read(RSEQ[i], 2'b11, "R8 seq read");
        measure(lo, hi, done);
        chk("R8 recall low phase", lo, DEPTH);
        chk("R8 recall no high phase", hi, 0);
        for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shadow[i];
        chk("R12 recall not counted", {29'd0, store_count}, exp_count);
        for (int i = 0; i < DEPTH; i++) do_read(AW'(i), 2'b11, "R8 recalled word");

        // Saturation
        while (exp_count < LIMIT) hw_store_measured("R12 fill");
        hw_store_measured("R12 saturated");

        // Reset recall restores shadow
        for (int i = 0; i < DEPTH; i++) do_write(AW'(i), 16'($urandom), 2'b11, 1'b0, 1'b1);
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        measure(lo, hi, done);
        chk("R10 reset recall low phase", lo, DEPTH);
        exp_count = 0;
        chk("R12 reset clears count", {29'd0, store_count}, 0);
        for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shadow[i];
        for (int i = 0; i < DEPTH; i++) do_read(AW'(i), 2'b11, "R10 shadow kept");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule